// File: doc/BRIEF.md
# Configuration Write Guard

This block sits beside a bank of configuration registers on a simple register bus and decides, for every bus write, whether the targeted register may take the data. It protects two groups of registers in two independent ways. The first group opens only after a two-step key sequence is written to a dedicated key slot. Each opening admits exactly one write: the first write to a guarded register, or any further key write, closes the gate again. The second group, which includes the global control register, is covered by a sticky lock bit kept in that control register. Once the bit is set, writes to the group are dropped until the next reset.

The guard gives one write-accept line per register slot. The surrounding register file stores bus data into a slot only while that slot's accept line is high at a clock edge. The guard's own state can be read back over the same bus. The key slot returns the sequence position and the control slot returns the sticky lock bit. The contents of the protected registers are held outside this block.

Default map (3-bit slot address): slot 0 is the global control register, slots 1 and 2 are lock-covered, slot 3 is unguarded, slot 4 is the key slot, and slots 5, 6 and 7 are key-guarded.

Top module: `cfg_write_guard`

## Requirements
- R1: After reset the key slot reads 0 (locked), the control slot reads 0 (lock clear), and no write-accept line is high while no write is presented.
- R2: In the locked state, writing 0xA5 in bits 7:0 to the key slot moves the key state to 1 (staged) on the next clock edge. Any other value leaves it at 0.
- R3: In the staged state, writing 0xF1 to the key slot moves the key state to 2 (open). Any other key value returns it to 0.
- R4: While the key state is 0 or 1, writes to slots 5 to 7 are not accepted. Such a write in state 1 also returns the state to 0, so a later 0xF1 does not open the gate.
- R5: In the open state, a write to a slot in 5 to 7 is accepted in the same cycle, and the key state returns to 0 on the following edge. A second write is therefore refused.
- R6: In the open state, any write to the key slot, including 0xA5, returns the key state to 0.
- R7: Writing the control slot (slot 0) with bit 31 set while the lock is clear sets the sticky lock. That write is accepted, and the control slot then reads 0x8000_0000.
- R8: While the sticky lock is set, writes to slots 0, 1 and 2 are not accepted, and the bit stays set whatever is written. Only reset clears it.
- R9: Writes to slot 3 are always accepted and leave the key state unchanged. The sticky lock does not affect the key-guarded slots.
- R10: A write-accept line rises only for the addressed slot and only while a write is presented. At most one line is high, and the key slot's line is never high.
- R11: Read data is combinational. The key slot returns the key state in bits 1:0 with all other bits zero, the control slot returns the lock in bit 31 with all other bits zero, and every other slot reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Slot address of the current access |
| bus_we | input | 1 | Write strobe for the current access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed slot |
| wr_accept | output | 2**ADDR_W (8) | Per-slot write qualifier for the register file |

## Verification
The write-accept lines depend only on the present bus access and on state already registered, so they are due in the same cycle as the write. The bench samples them 1 ns after it drives the access on the falling edge. Key state and lock change on the rising edge that ends the write cycle. Because read data is combinational, their new values are due in the cycle that follows, and the bench reads them back after the next falling edge. The bench keeps a model register file that stores data only when the accept line it sampled was high. Each time, it compares that file with the contents the requirements predict, so a refused write is seen as contents left unchanged.

// File: rtl/cwg_pkg.sv
// Package: shared types for the configuration write guard.
// Assumes: key state encoding is visible to software, so values are fixed.
package cwg_pkg;

    // Key sequence position; numeric values are the read-back code.
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_STAGED = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    // Classification of the addressed slot.
    typedef struct packed {
        logic is_key;
        logic is_ctrl;
        logic in_keygrp;
        logic in_stickygrp;
    } slot_class_t;

endpackage

// File: rtl/cwg_decode.sv
// Module: cwg_decode
// Turns a slot address into a one-hot slot vector and a class record.
// Assumes: the key slot is in neither mask; the control slot is covered by
// the sticky lock whether or not STICKY_MASK names it.
module cwg_decode
    import cwg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NSLOT = 1 << ADDR_W,
    parameter int KEY_SLOT = 4,
    parameter int CTRL_SLOT = 0,
    parameter logic [NSLOT-1:0] KEY_MASK = '0,
    parameter logic [NSLOT-1:0] STICKY_MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSLOT-1:0]  slot_hot,
    output slot_class_t       cls
);

    localparam logic [NSLOT-1:0] STICKY_ALL =
        STICKY_MASK | (NSLOT'(1) << CTRL_SLOT);

    // One comparator per slot.
    for (genvar i = 0; i < NSLOT; i++) begin : g_hot
        assign slot_hot[i] = (addr == ADDR_W'(i));
    end

    // Class flags derived from the one-hot vector and the masks.
    always_comb begin
        cls.is_key       = slot_hot[KEY_SLOT];
        cls.is_ctrl      = slot_hot[CTRL_SLOT];
        cls.in_keygrp    = |(slot_hot & KEY_MASK);
        cls.in_stickygrp = |(slot_hot & STICKY_ALL);
    end

endmodule

// File: rtl/cwg_key_fsm.sv
// Module: cwg_key_fsm
// Three-state key sequencer: locked -> staged -> open, single-use opening.
// Assumes: key_wr and guarded_wr are never high together (distinct slots).
module cwg_key_fsm
    import cwg_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_FIRST = 8'hA5,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             guarded_wr,
    output key_state_e       state,
    output logic             gate_open
);

    key_state_e state_q, state_d;

    // Next-state rules for the key sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: begin
                if (key_wr && key_val == KEY_FIRST) state_d = KS_STAGED;
            end
            KS_STAGED: begin
                if (key_wr) state_d = (key_val == KEY_SECOND) ? KS_OPEN : KS_LOCKED;
                else if (guarded_wr) state_d = KS_LOCKED;
            end
            KS_OPEN: begin
                if (key_wr || guarded_wr) state_d = KS_LOCKED;
            end
            default: state_d = KS_LOCKED;
        endcase
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign state     = state_q;
    assign gate_open = (state_q == KS_OPEN);

endmodule

// File: rtl/cwg_sticky_lock.sv
// Module: cwg_sticky_lock
// Set-only lock bit, loaded from an accepted control-register write.
// Assumes: ctrl_wr is already qualified by the lock itself.
module cwg_sticky_lock #(
    parameter int DATA_W = 32,
    parameter int LOCK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);

    logic lock_q;

    // Set on an accepted write with the lock bit high; only reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lock_q <= 1'b0;
        else if (ctrl_wr && wdata[LOCK_BIT]) lock_q <= 1'b1;
    end

    assign locked = lock_q;

endmodule

// File: rtl/cfg_write_guard.sv
// Module: cfg_write_guard (top)
// Qualifies register-bus writes per slot using a key sequence and a sticky
// lock, and returns the guard state on reads.
// Assumes: one access per cycle; the register file stores data only in a
// cycle where its wr_accept line is high.
module cfg_write_guard
    import cwg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int KEY_W = 8,
    parameter int KEY_SLOT = 4,
    parameter int CTRL_SLOT = 0,
    parameter int LOCK_BIT = 31,
    parameter logic [KEY_W-1:0] KEY_FIRST = 8'hA5,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1,
    parameter logic [(1<<ADDR_W)-1:0] KEY_MASK = 8'b1110_0000,
    parameter logic [(1<<ADDR_W)-1:0] STICKY_MASK = 8'b0000_0111
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [(1<<ADDR_W)-1:0]   wr_accept
);

    localparam int NSLOT = 1 << ADDR_W;
    localparam logic [NSLOT-1:0] STICKY_ALL =
        STICKY_MASK | (NSLOT'(1) << CTRL_SLOT);

    logic [NSLOT-1:0] slot_hot;
    slot_class_t      cls;
    key_state_e       key_state;
    logic             gate_open;
    logic             lock_q;
    logic             key_wr;
    logic             guarded_wr;
    logic             ctrl_wr_ok;

    cwg_decode #(
        .ADDR_W(ADDR_W), .NSLOT(NSLOT), .KEY_SLOT(KEY_SLOT),
        .CTRL_SLOT(CTRL_SLOT), .KEY_MASK(KEY_MASK), .STICKY_MASK(STICKY_MASK)
    ) u_decode (
        .addr(bus_addr), .slot_hot(slot_hot), .cls(cls)
    );

    // Write attempts that the key sequencer reacts to.
    assign key_wr     = bus_we & cls.is_key;
    assign guarded_wr = bus_we & cls.in_keygrp;
    assign ctrl_wr_ok = wr_accept[CTRL_SLOT];

    cwg_key_fsm #(
        .KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key_val(bus_wdata[KEY_W-1:0]), .guarded_wr(guarded_wr),
        .state(key_state), .gate_open(gate_open)
    );

    cwg_sticky_lock #(
        .DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr_ok),
        .wdata(bus_wdata), .locked(lock_q)
    );

    // Per-slot qualifier; the variant depends on which protections apply.
    for (genvar i = 0; i < NSLOT; i++) begin : g_acc
        if (i == KEY_SLOT) begin : g_key
            assign wr_accept[i] = 1'b0;
        end else begin : g_reg
            localparam logic NEED_KEY = KEY_MASK[i];
            localparam logic NEED_UNLK = STICKY_ALL[i];
            assign wr_accept[i] = bus_we & slot_hot[i]
                                & (!NEED_KEY  | gate_open)
                                & (!NEED_UNLK | !lock_q);
        end
    end

    // Read-back mux for the guard's own state.
    always_comb begin
        bus_rdata = '0;
        if (cls.is_key)       bus_rdata[KEY_W-1:0] = {{(KEY_W-2){1'b0}}, key_state};
        else if (cls.is_ctrl) bus_rdata[LOCK_BIT]  = lock_q;
    end

endmodule

// File: rtl/cwg_guard_chk.sv
// Module: cwg_guard_chk
// Assertion checker bound to cfg_write_guard.
// Assumes: key_state uses the read-back encoding 0/1/2.
module cwg_guard_chk #(
    parameter int ADDR_W = 3,
    parameter int KEY_W = 8,
    parameter int KEY_SLOT = 4,
    parameter int CTRL_SLOT = 0,
    parameter logic [KEY_W-1:0] KEY_FIRST = 8'hA5,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'hF1,
    parameter logic [(1<<ADDR_W)-1:0] KEY_MASK = 8'b1110_0000,
    parameter logic [(1<<ADDR_W)-1:0] STICKY_MASK = 8'b0000_0111
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [31:0]            bus_wdata,
    input logic [(1<<ADDR_W)-1:0] wr_accept,
    input logic [1:0]             key_state,
    input logic                   lock_q
);

    localparam int NSLOT = 1 << ADDR_W;
    localparam logic [NSLOT-1:0] STICKY_ALL =
        STICKY_MASK | (NSLOT'(1) << CTRL_SLOT);

    logic in_key, in_keygrp, in_sticky;
    // Independent slot decode for the properties.
    always_comb begin
        in_key    = (int'(bus_addr) == KEY_SLOT);
        in_keygrp = KEY_MASK[bus_addr];
        in_sticky = STICKY_ALL[bus_addr];
    end

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_accept));
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |-> wr_accept == '0);
    a_r10_key_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_accept[KEY_SLOT]);
    a_r2_first_key: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state == 2'd0 && bus_we && in_key && bus_wdata[KEY_W-1:0] == KEY_FIRST)
        |=> key_state == 2'd1);
    a_r3_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state == 2'd1 && bus_we && in_key && bus_wdata[KEY_W-1:0] == KEY_SECOND)
        |=> key_state == 2'd2);
    a_r4_block: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state != 2'd2 && bus_we && in_keygrp) |-> wr_accept == '0);
    a_r5_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state == 2'd2 && bus_we && in_keygrp) |=> key_state == 2'd0);
    a_r6_key_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (key_state == 2'd2 && bus_we && in_key) |=> key_state == 2'd0);
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && bus_we && in_sticky) |-> wr_accept == '0);

endmodule

bind cfg_write_guard cwg_guard_chk #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY_SLOT(KEY_SLOT), .CTRL_SLOT(CTRL_SLOT),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
    .KEY_MASK(KEY_MASK), .STICKY_MASK(STICKY_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata[31:0]), .wr_accept(wr_accept),
    .key_state(key_state), .lock_q(lock_q)
);

// File: tb/cfg_write_guard_tb.sv
module cfg_write_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  wr_accept;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] shadow [8];
    logic [31:0] expreg [8];

    always #4 clk = ~clk;

    cfg_write_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_accept(wr_accept)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one write; check accept lines in the same cycle.
    task automatic wr(input int a, input logic [31:0] d, input bit exp_acc, input string req);
        logic acc;
        @(negedge clk);
        bus_addr = 3'(a); bus_we = 1'b1; bus_wdata = d;
        #1;
        acc = wr_accept[a];
        chk(req, 32'(acc), 32'(exp_acc));
        chk("R10", 32'(wr_accept & ~(8'd1 << a)), 32'd0);
        if (acc) shadow[a] = d;
        if (exp_acc) expreg[a] = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = 3'(a); bus_we = 1'b0;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < 8; i++) chk(req, shadow[i], expreg[i]);
    endtask

    task automatic t_reset();
        do_reset();
        rd(4, 32'd0, "R1");
        rd(0, 32'd0, "R1");
        #1 chk("R1", 32'(wr_accept), 32'd0);
        rd(5, 32'd0, "R11");
    endtask

    task automatic t_locked_drop();
        wr(5, 32'h1111_0005, 1'b0, "R4");
        rd(4, 32'd0, "R4");
        chk_regs("R4");
    endtask

    task automatic t_first_key();
        wr(4, 32'h0000_005A, 1'b0, "R10");
        rd(4, 32'd0, "R2");
        wr(4, 32'h0000_00A5, 1'b0, "R10");
        rd(4, 32'd1, "R2");
    endtask

    task automatic t_bad_second();
        wr(4, 32'h0000_0033, 1'b0, "R10");
        rd(4, 32'd0, "R3");
    endtask

    task automatic t_unlock();
        wr(4, 32'h0000_00A5, 1'b0, "R10");
        wr(4, 32'h0000_00F1, 1'b0, "R10");
        rd(4, 32'd2, "R3");
    endtask

    task automatic t_single_use();
        t_unlock();
        wr(6, 32'hCAFE_0006, 1'b1, "R5");
        rd(4, 32'd0, "R5");
        wr(6, 32'hDEAD_0006, 1'b0, "R5");
        chk_regs("R5");
    endtask

    task automatic t_staged_abort();
        wr(4, 32'h0000_00A5, 1'b0, "R10");
        wr(7, 32'h7777_0007, 1'b0, "R4");
        rd(4, 32'd0, "R4");
        wr(4, 32'h0000_00F1, 1'b0, "R10");
        rd(4, 32'd0, "R4");
        chk_regs("R4");
    endtask

    task automatic t_key_relock();
        t_unlock();
        wr(4, 32'h0000_00A5, 1'b0, "R10");
        rd(4, 32'd0, "R6");
        wr(5, 32'h5555_0005, 1'b0, "R6");
        chk_regs("R6");
    endtask

    task automatic t_open_slot();
        t_unlock();
        wr(3, 32'h3333_0003, 1'b1, "R9");
        rd(4, 32'd2, "R9");
        wr(5, 32'h5A5A_0005, 1'b1, "R9");
        rd(3, 32'd0, "R11");
    endtask

    task automatic t_sticky();
        wr(1, 32'h0101_0101, 1'b1, "R7");
        wr(0, 32'h8000_0012, 1'b1, "R7");
        rd(0, 32'h8000_0000, "R7");
        wr(1, 32'h0202_0202, 1'b0, "R8");
        wr(2, 32'h0303_0303, 1'b0, "R8");
        wr(0, 32'h0000_0000, 1'b0, "R8");
        rd(0, 32'h8000_0000, "R8");
        wr(3, 32'h3333_1111, 1'b1, "R9");
        t_unlock();
        wr(7, 32'h7777_1111, 1'b1, "R9");
        chk_regs("R8");
        do_reset();
        rd(0, 32'd0, "R8");
        rd(4, 32'd0, "R1");
        wr(1, 32'h0404_0404, 1'b1, "R8");
        chk_regs("R8");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            shadow[i] = '0;
            expreg[i] = '0;
        end
        t_reset();
        t_locked_drop();
        t_first_key();
        t_bad_second();
        t_unlock();
        do_reset();
        t_single_use();
        t_staged_abort();
        t_key_relock();
        t_open_slot();
        t_sticky();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule